// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block walks the eight channels of a pair of cascaded four-channel DMA controllers. Controller 0 moves bytes and controller 1 moves 16-bit words. A single pulse on `scan_trig` starts a pass. The pass visits channels 0 to 7 in fixed order, and channels 4 to 7 belong to the word controller. A channel is served when its mask bit is clear and its request bit is set. Serving a channel means presenting a transfer request to an external transfer agent and waiting for the agent's completion pulse.

For a served channel the scheduler forms a 24-bit start address. The page byte of the channel sits above a 16-bit current address. For word channels the current address is the programmed base address shifted left by one bit. The scheduler also forms a transfer length from the programmed base count, scaled the same way for word channels. When the agent completes, the count it returns is stored as that channel's transferred count. If the agent flags an interrupt, the scheduler emits a one-cycle interrupt pulse carrying the agent's interrupt number. Request bits are set and cleared through hold and release inputs that take a channel number from 0 to 7. A new trigger that arrives while a pass is running is dropped, and its arrival is flagged.

Top module: `dma_svc_sched`

## Requirements
- R1: A pass visits channel indices 0 through 7 in ascending order. Indices 0–3 are the byte controller and 4–7 are the word controller. `xfer_chan` carries the index of the channel being served.
- R2: A channel is served only if `chan_mask[c]` is 0 and `req_bits[c]` is 1 when the pass reaches it.
- R3: `xfer_addr[23:16]` is the channel's page byte and `xfer_addr[15:0]` is its current address.
- R4: `xfer_len` equals base_count + 1 for byte channels and (base_count << 1) + 2 for word channels, with no truncation (18 bits).
- R5: The current address of a word channel is its base address shifted left by one bit, truncated to 16 bits. For a byte channel the current address is the base address.
- R6: `xfer_start` is a one-cycle pulse. The pass stays on the served channel until `xfer_done` is seen, so at most one request is outstanding.
- R7: The `xfer_count` value sampled with `xfer_done` is written to that channel's slot in `cur_cnt_flat`. Slot c occupies bits [16c+15:16c].
- R8: When `xfer_done` comes with `xfer_irq_valid` high, `irq_pulse` is high for one cycle on the next cycle and `irq_num` equals `xfer_irq_num`. Otherwise no pulse is produced.
- R9: A `scan_trig` sampled while `scan_busy` is high does not restart the pass. It raises `retrig_flag` for one cycle on the next cycle.
- R10: A channel that is not served takes exactly one cycle. `scan_done` pulses for one cycle as the pass leaves channel 7, and `scan_busy` is then low. A pass with no served channel keeps `scan_busy` high for 8 cycles.
- R11: `hold_valid` sets `req_bits[hold_chan]` and `rel_valid` clears `req_bits[rel_chan]`. If both name the same channel in the same cycle, the set wins.
- R12: After reset, `scan_busy`, `xfer_start`, `scan_done`, `irq_pulse`, `retrig_flag`, `req_bits` and all transferred counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_trig | input | 1 | Start a pass (ignored while busy) |
| chan_mask | input | 8 | Per-channel mask, 1 = blocked |
| hold_valid | input | 1 | Set request bit of `hold_chan` |
| hold_chan | input | 3 | Channel to set |
| rel_valid | input | 1 | Clear request bit of `rel_chan` |
| rel_chan | input | 3 | Channel to clear |
| page_flat | input | 64 | Page byte per channel, channel c at [8c+7:8c] |
| base_addr_flat | input | 128 | Base address per channel, 16 bits each |
| base_cnt_flat | input | 128 | Base count per channel, 16 bits each |
| xfer_start | output | 1 | One-cycle transfer request |
| xfer_chan | output | 3 | Channel being served |
| xfer_addr | output | 24 | Transfer start address |
| xfer_len | output | 18 | Transfer length |
| xfer_done | input | 1 | Agent completion pulse |
| xfer_count | input | 16 | Count returned by the agent |
| xfer_irq_valid | input | 1 | Agent reports an interrupt |
| xfer_irq_num | input | 4 | Interrupt number from the agent |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_num | output | 4 | Interrupt number of the pulse |
| req_bits | output | 8 | Request bits per channel |
| cur_cnt_flat | output | 128 | Transferred count per channel |
| scan_busy | output | 1 | Pass in progress |
| scan_done | output | 1 | One-cycle end-of-pass pulse |
| retrig_flag | output | 1 | A trigger was dropped while busy |

## Verification
A wrong channel index shows up as a wrong `xfer_chan`, address or length in the very cycle `xfer_start` rises. It also shows up as a `scan_done` that arrives a cycle early or late. A wrong wait state would issue a second start or advance before `xfer_done`, and this appears within one cycle of the agent's latency window. A corrupted request or count register shows on `req_bits` or `cur_cnt_flat` one cycle after the hold, release or done input that wrote it. The bench therefore compares every output against a behavioural model on every clock.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_VISIT = 2'd1,
      ST_WAIT  = 2'd2
   } sched_state_e;
endpackage

// File: rtl/dma_req_bits.sv
module dma_req_bits #(
   parameter int NCH = 8,
   localparam int CIW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold_valid,
   input  logic [CIW-1:0] hold_chan,
   input  logic           rel_valid,
   input  logic [CIW-1:0] rel_chan,
   output logic [NCH-1:0] req_q
);
   for (genvar c = 0; c < NCH; c++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            req_q[c] <= 1'b0;
         else if (hold_valid && hold_chan == CIW'(c))
            req_q[c] <= 1'b1;
         else if (rel_valid && rel_chan == CIW'(c))
            req_q[c] <= 1'b0;
      end
   end

   a_r11_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid |=> req_q[$past(hold_chan)]);
   a_r11_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !(hold_valid && hold_chan == rel_chan)) |=> !req_q[$past(rel_chan)]);
endmodule

// File: rtl/dma_chan_calc.sv
module dma_chan_calc #(
   parameter int NCTRL  = 2,
   parameter int CH_PER = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int PW     = 8,
   localparam int NCH   = NCTRL * CH_PER,
   localparam int CIW   = $clog2(NCH),
   localparam int LW    = CW + NCTRL
) (
   input  logic [NCH*PW-1:0] page_flat,
   input  logic [NCH*AW-1:0] base_addr_flat,
   input  logic [NCH*CW-1:0] base_cnt_flat,
   input  logic [CIW-1:0]    sel,
   output logic [PW+AW-1:0]  addr,
   output logic [LW-1:0]     len
);
   logic [PW+AW-1:0] addr_c [NCH];
   logic [LW-1:0]    len_c  [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int SH = c / CH_PER;   // controller index scales the unit
      logic [AW-1:0] cur_a;
      logic [LW-1:0] cnt_ext;
      assign cur_a     = base_addr_flat[c*AW +: AW] << SH;
      assign cnt_ext   = LW'(base_cnt_flat[c*CW +: CW]) << SH;
      assign addr_c[c] = {page_flat[c*PW +: PW], cur_a};
      assign len_c[c]  = cnt_ext + (LW'(1) << SH);
   end

   assign addr = addr_c[sel];
   assign len  = len_c[sel];
endmodule

// File: rtl/dma_scan_fsm.sv
module dma_scan_fsm
   import dma_sched_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int XW   = 24,
   parameter int LW   = 18,
   parameter int CW   = 16,
   parameter int IRQW = 4,
   localparam int CIW = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scan_trig,
   input  logic            qualify,
   input  logic [XW-1:0]   calc_addr,
   input  logic [LW-1:0]   calc_len,
   input  logic            xfer_done,
   input  logic [CW-1:0]   xfer_count,
   input  logic            xfer_irq_valid,
   input  logic [IRQW-1:0] xfer_irq_num,
   output logic [CIW-1:0]  idx,
   output logic            xfer_start,
   output logic [XW-1:0]   xfer_addr,
   output logic [LW-1:0]   xfer_len,
   output logic            irq_pulse,
   output logic [IRQW-1:0] irq_num,
   output logic [NCH*CW-1:0] cur_cnt_flat,
   output logic            scan_busy,
   output logic            scan_done,
   output logic            retrig_flag
);
   sched_state_e state;
   logic [CW-1:0] cnt_q [NCH];
   logic last;

   assign last      = (idx == CIW'(NCH-1));
   assign scan_busy = (state != ST_IDLE);

   for (genvar c = 0; c < NCH; c++) begin : g_cnt
      assign cur_cnt_flat[c*CW +: CW] = cnt_q[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         idx         <= '0;
         xfer_start  <= 1'b0;
         xfer_addr   <= '0;
         xfer_len    <= '0;
         irq_pulse   <= 1'b0;
         irq_num     <= '0;
         scan_done   <= 1'b0;
         retrig_flag <= 1'b0;
         for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
      end else begin
         xfer_start  <= 1'b0;
         irq_pulse   <= 1'b0;
         scan_done   <= 1'b0;
         retrig_flag <= scan_trig && (state != ST_IDLE);
         case (state)
            ST_IDLE: if (scan_trig) begin
               state <= ST_VISIT;
               idx   <= '0;
            end
            ST_VISIT: begin
               if (qualify) begin
                  xfer_start <= 1'b1;
                  xfer_addr  <= calc_addr;
                  xfer_len   <= calc_len;
                  state      <= ST_WAIT;
               end else if (last) begin
                  scan_done <= 1'b1;
                  state     <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_WAIT: if (xfer_done) begin
               cnt_q[idx] <= xfer_count;
               irq_pulse  <= xfer_irq_valid;
               irq_num    <= xfer_irq_num;
               if (last) begin
                  scan_done <= 1'b1;
                  state     <= ST_IDLE;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_VISIT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);
   a_r6_start_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> scan_busy);
   a_r8_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(xfer_done && xfer_irq_valid));
   a_r9_flag_only_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      retrig_flag |-> (scan_busy || scan_done));
   a_r10_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !scan_busy);
endmodule

// File: rtl/dma_svc_sched.sv
module dma_svc_sched #(
   parameter int NCTRL  = 2,
   parameter int CH_PER = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int PW     = 8,
   parameter int IRQW   = 4,
   localparam int NCH   = NCTRL * CH_PER,
   localparam int CIW   = $clog2(NCH),
   localparam int XW    = PW + AW,
   localparam int LW    = CW + NCTRL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_trig,
   input  logic [NCH-1:0]    chan_mask,
   input  logic              hold_valid,
   input  logic [CIW-1:0]    hold_chan,
   input  logic              rel_valid,
   input  logic [CIW-1:0]    rel_chan,
   input  logic [NCH*PW-1:0] page_flat,
   input  logic [NCH*AW-1:0] base_addr_flat,
   input  logic [NCH*CW-1:0] base_cnt_flat,
   output logic              xfer_start,
   output logic [CIW-1:0]    xfer_chan,
   output logic [XW-1:0]     xfer_addr,
   output logic [LW-1:0]     xfer_len,
   input  logic              xfer_done,
   input  logic [CW-1:0]     xfer_count,
   input  logic              xfer_irq_valid,
   input  logic [IRQW-1:0]   xfer_irq_num,
   output logic              irq_pulse,
   output logic [IRQW-1:0]   irq_num,
   output logic [NCH-1:0]    req_bits,
   output logic [NCH*CW-1:0] cur_cnt_flat,
   output logic              scan_busy,
   output logic              scan_done,
   output logic              retrig_flag
);
   if (NCTRL != 2) begin : g_bad_nctrl
      $error("dma_svc_sched: exactly two cascaded controllers are supported");
   end
   if (CH_PER < 1 || (CH_PER & (CH_PER - 1)) != 0) begin : g_bad_chper
      $error("dma_svc_sched: CH_PER must be a power of two");
   end
   if (AW < 2 || CW < 1 || PW < 1 || IRQW < 1) begin : g_bad_width
      $error("dma_svc_sched: field widths out of range");
   end

   logic [CIW-1:0] idx;
   logic [XW-1:0]  calc_addr;
   logic [LW-1:0]  calc_len;
   logic           qualify;

   dma_req_bits #(.NCH(NCH)) u_req (
      .clk(clk), .rst_n(rst_n),
      .hold_valid(hold_valid), .hold_chan(hold_chan),
      .rel_valid(rel_valid), .rel_chan(rel_chan),
      .req_q(req_bits)
   );

   dma_chan_calc #(.NCTRL(NCTRL), .CH_PER(CH_PER), .AW(AW), .CW(CW), .PW(PW)) u_calc (
      .page_flat(page_flat), .base_addr_flat(base_addr_flat),
      .base_cnt_flat(base_cnt_flat), .sel(idx),
      .addr(calc_addr), .len(calc_len)
   );

   assign qualify = !chan_mask[idx] && req_bits[idx];

   dma_scan_fsm #(.NCH(NCH), .XW(XW), .LW(LW), .CW(CW), .IRQW(IRQW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scan_trig(scan_trig), .qualify(qualify),
      .calc_addr(calc_addr), .calc_len(calc_len),
      .xfer_done(xfer_done), .xfer_count(xfer_count),
      .xfer_irq_valid(xfer_irq_valid), .xfer_irq_num(xfer_irq_num),
      .idx(idx), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
      .xfer_len(xfer_len), .irq_pulse(irq_pulse), .irq_num(irq_num),
      .cur_cnt_flat(cur_cnt_flat), .scan_busy(scan_busy),
      .scan_done(scan_done), .retrig_flag(retrig_flag)
   );

   assign xfer_chan = idx;

   a_r2_start_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(qualify));
   a_r6_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && !xfer_done && !xfer_start && $past(xfer_start)) |-> $stable(xfer_chan));
endmodule

// File: tb/sim_dma_svc_sched.sv
module sim_dma_svc_sched;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic         scan_trig = 0;
   logic [7:0]   chan_mask = 0;
   logic         hold_valid = 0, rel_valid = 0;
   logic [2:0]   hold_chan = 0, rel_chan = 0;
   logic [63:0]  page_flat = 0;
   logic [127:0] base_addr_flat = 0, base_cnt_flat = 0;
   logic         xfer_done = 0, xfer_irq_valid = 0;
   logic [15:0]  xfer_count = 0;
   logic [3:0]   xfer_irq_num = 0;
   logic         xfer_start, irq_pulse, scan_busy, scan_done, retrig_flag;
   logic [2:0]   xfer_chan;
   logic [23:0]  xfer_addr;
   logic [17:0]  xfer_len;
   logic [3:0]   irq_num;
   logic [7:0]   req_bits;
   logic [127:0] cur_cnt_flat;

   dma_svc_sched u0 (.*);

   int checks = 0, fails = 0, cyc = 0;
   bit summary_done = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // transfer agent
   int ag_lat = 2, ag_cd = 0;
   logic [2:0] ag_chan = 0;
   always @(posedge clk) begin
      #1;
      if (ag_cd > 0) begin
         ag_cd--;
         if (ag_cd == 0) begin
            xfer_done = 1; xfer_count = 16'h0100 + 16'(ag_chan) * 7;
            xfer_irq_valid = ag_chan[0]; xfer_irq_num = 4'(ag_chan) + 4'd3;
         end else begin
            xfer_done = 0; xfer_irq_valid = 0;
         end
      end else begin
         xfer_done = 0; xfer_irq_valid = 0;
      end
      if (xfer_start) begin ag_chan = xfer_chan; ag_cd = ag_lat; end
   end

   // behavioural reference model, checked and stepped each negedge
   bit m_busy, m_wait, m_start, m_done, m_irq, m_ign;
   int m_idx;
   logic [3:0]  m_irqn;
   logic [7:0]  m_req;
   logic [15:0] m_cnt [8];
   logic [23:0] m_addr;
   logic [17:0] m_len;

   function automatic logic [23:0] ref_addr(int c);
      int k = c / 4;
      logic [15:0] cur = 16'(base_addr_flat[c*16 +: 16] << k);
      return {page_flat[c*8 +: 8], cur};
   endfunction
   function automatic logic [17:0] ref_len(int c);
      int k = c / 4;
      return (18'(base_cnt_flat[c*16 +: 16]) << k) + (18'd1 << k);
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_wait = 0; m_start = 0; m_done = 0; m_irq = 0; m_ign = 0;
         m_idx = 0; m_irqn = 0; m_req = 0;
         for (int c = 0; c < 8; c++) m_cnt[c] = 0;
      end else begin
         cyc++;
         chk(scan_busy === m_busy, "R10 busy", 32'(scan_busy), 32'(m_busy));
         chk(xfer_start === m_start, "R6/R2 start", 32'(xfer_start), 32'(m_start));
         if (m_start) begin
            chk(xfer_chan === 3'(m_idx), "R1 chan order", 32'(xfer_chan), 32'(m_idx));
            chk(xfer_addr === m_addr, "R3/R5 addr", 32'(xfer_addr), 32'(m_addr));
            chk(xfer_len === m_len, "R4 len", 32'(xfer_len), 32'(m_len));
         end
         chk(scan_done === m_done, "R10 done", 32'(scan_done), 32'(m_done));
         chk(irq_pulse === m_irq, "R8 irq", 32'(irq_pulse), 32'(m_irq));
         if (m_irq) chk(irq_num === m_irqn, "R8 irq num", 32'(irq_num), 32'(m_irqn));
         chk(retrig_flag === m_ign, "R9 retrig", 32'(retrig_flag), 32'(m_ign));
         chk(req_bits === m_req, "R11 req", 32'(req_bits), 32'(m_req));
         for (int c = 0; c < 8; c++)
            chk(cur_cnt_flat[c*16 +: 16] === m_cnt[c], "R7 count", 32'(cur_cnt_flat[c*16 +: 16]), 32'(m_cnt[c]));
         // step
         m_start = 0; m_done = 0; m_irq = 0; m_ign = 0;
         if (!m_busy) begin
            if (scan_trig) begin m_busy = 1; m_idx = 0; m_wait = 0; end
         end else begin
            if (scan_trig) m_ign = 1;
            if (!m_wait) begin
               if (!chan_mask[m_idx] && m_req[m_idx]) begin
                  m_start = 1; m_wait = 1;
                  m_addr = ref_addr(m_idx); m_len = ref_len(m_idx);
               end else if (m_idx == 7) begin m_busy = 0; m_done = 1; end
               else m_idx++;
            end else if (xfer_done) begin
               m_cnt[m_idx] = xfer_count;
               if (xfer_irq_valid) begin m_irq = 1; m_irqn = xfer_irq_num; end
               m_wait = 0;
               if (m_idx == 7) begin m_busy = 0; m_done = 1; end
               else m_idx++;
            end
         end
         if (rel_valid) m_req[rel_chan] = 0;
         if (hold_valid) m_req[hold_chan] = 1;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask
   task automatic trig();
      tick(); scan_trig = 1; tick(); scan_trig = 0;
   endtask
   task automatic hold(input int c);
      tick(); hold_valid = 1; hold_chan = 3'(c); tick(); hold_valid = 0;
   endtask
   task automatic rel(input int c);
      tick(); rel_valid = 1; rel_chan = 3'(c); tick(); rel_valid = 0;
   endtask
   task automatic wait_idle();
      int guard = 0;
      tick();
      while (scan_busy && guard < 500) begin tick(); guard++; end
      tick(2);
   endtask
   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
   end

   initial begin
      for (int c = 0; c < 8; c++) begin
         page_flat[c*8 +: 8]        = 8'h20 + 8'(c);
         base_addr_flat[c*16 +: 16] = 16'h1000 + 16'(c) * 16'h0111;
         base_cnt_flat[c*16 +: 16]  = 16'h0010 + 16'(c);
      end
      base_addr_flat[7*16 +: 16] = 16'hC001;   // R5 truncation on word shift
      base_cnt_flat[7*16 +: 16]  = 16'hFFFF;   // R4 full-width length
      base_cnt_flat[3*16 +: 16]  = 16'hFFFF;   // R4 byte-controller max
      tick(3);
      rst_n = 1;
      tick();
      // R12 reset state at the ports
      chk(!scan_busy && !xfer_start && !scan_done && !irq_pulse && !retrig_flag,
          "R12 reset outputs", 32'({scan_busy, xfer_start, scan_done, irq_pulse, retrig_flag}), 0);
      chk(req_bits === 8'h00, "R12 reset req", 32'(req_bits), 0);
      chk(cur_cnt_flat === '0, "R12 reset counts", 32'(cur_cnt_flat[31:0]), 0);

      // R10: empty pass, eight idle cycles
      trig(); wait_idle();

      // R1 R2 R3 R4 R5 R7 R8: mixed requests, one masked, with retrigger (R9)
      hold(1); hold(2); hold(5); hold(7);
      chan_mask = 8'b0000_0100;
      ag_lat = 2;
      trig(); tick(3); scan_trig = 1; tick(); scan_trig = 0;
      wait_idle();

      // R11: release, hold+release same cycle, hold during pass on visited channel
      rel(1);
      tick(); hold_valid = 1; hold_chan = 3'd3; rel_valid = 1; rel_chan = 3'd3;
      tick(); hold_valid = 0; rel_valid = 0;
      chan_mask = 8'h00; ag_lat = 4;
      trig(); tick(2); hold(0);
      wait_idle();

      // R2: everything masked, nothing served
      hold(6); rel(7);
      chan_mask = 8'hFF;
      trig(); wait_idle();

      // last pass, latency 1, retrigger at the last cycle
      chan_mask = 8'h00; ag_lat = 1;
      trig(); tick(6); scan_trig = 1; tick(); scan_trig = 0;
      wait_idle();
      tick(3);
      finish_run();
   end
endmodule